// File: doc/BRIEF.md
# Programmable Sample Delay Line

This block delays a stream of signed samples by a whole number of sample slots that can be changed while the stream runs. It sits in a beam feedback path between the gain stage and the first notch filter. Setting the length sets the loop delay, and through it the pickup-to-kicker phase, which must stay between -90 and +90 degrees. When every clock carries a sample, the delay is the programmed length times the clock period. Each accepted sample is stored in a ring buffer at a write pointer. A read pointer sits the programmed number of slots behind the write pointer. Both pointers run on the same clock and wrap modulo the buffer depth.

After the length changes, the slots behind the write pointer still hold samples from the old setting. The block outputs zeros until enough new samples have arrived to fill the new span, so it never emits one of those stale samples. A bypass control, or a length of zero, routes each input sample straight to the output through one register stage. Every path through the block has the same one-cycle latency from input strobe to output strobe.

Top module: `sample_delay_line`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_data is 0.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid is high. Idle cycles do not move any pointer, so the delay is counted in accepted samples.
- R3: With an effective length L from 1 to DEPTH and a full buffer, the output for the n-th accepted sample is the (n-L)-th accepted sample.
- R4: After the effective length changes to L > 0, the output is 0 for the first L samples accepted. The sample accepted in the cycle of the change counts as the first new sample. Sample L+1 onward follow R3.
- R5: While bypass is 1, the output for a sample is that same sample, one cycle later. Bypass overrides the zero forcing of R4. Samples are still written while bypass is 1, and they count toward the refill.
- R6: An effective length of 0 gives the same output as bypass.
- R7: out_data is 0 in every cycle in which out_valid is 0.
- R8: A cfg_len value above DEPTH acts as DEPTH. A change between two values that both act as DEPTH is not a length change, so it does not restart the refill.
- R9: At length DEPTH, after more than DEPTH samples, the pointers wrap. The block reads the slot that is being overwritten in the same cycle and returns its old content, which is the sample exactly DEPTH samples back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both pointers advance on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample, two's complement |
| cfg_len | input | LEN_W | Delay length in samples; 0 selects the direct path |
| bypass | input | 1 | 1 routes the input straight to the output |
| out_valid | output | 1 | Output sample strobe, one cycle after in_valid |
| out_data | output | DATA_W | Delayed sample, or 0 while refilling or idle |

## Verification
The hardest condition to reach from the ports is a read and a write to the same slot of the ring in the same cycle. This happens only at the largest length, once more than a buffer's worth of samples has passed. The stimulus holds the length at DEPTH for over two thousand back-to-back samples to create it. It then moves cfg_len between two values above DEPTH, to show that no refill starts. Other directed phases toggle bypass in the middle of a refill and alternate between lengths 0 and 1. A seeded random phase then changes the length, the strobe density and bypass at random points.

// File: rtl/dl_pkg.sv
package dl_pkg;

   // Source picked for the output register
   typedef enum logic [1:0] {
      SEL_RAM    = 2'd0,
      SEL_DIRECT = 2'd1,
      SEL_ZERO   = 2'd2
   } dl_sel_e;

   // Effective length: values above the depth act as the depth
   function automatic int unsigned clamp_len(input int unsigned len, input int unsigned depth);
      return (len > depth) ? depth : len;
   endfunction

endpackage

// File: rtl/dl_ram.sv
module dl_ram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   // Write port
   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // Read port, old data on a same-address collision
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/dl_ctrl.sv
module dl_ctrl #(
   parameter int DEPTH = 1024,
   parameter int AW    = $clog2(DEPTH),
   parameter int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [LEN_W-1:0] cfg_len,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    rd_addr,
   output logic             filled,
   output logic             len_zero
);

   localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
   localparam bit               POW2    = ((DEPTH & (DEPTH - 1)) == 0);
   localparam int               SUM_W   = LEN_W + 1;

   logic [LEN_W-1:0] len_sat;
   logic [LEN_W-1:0] len_q;
   logic             len_chg;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] cnt_eff;
   logic [LEN_W-1:0] cnt_nxt;
   logic [AW-1:0]    wp_q;
   logic [AW-1:0]    wp_nxt;

   // Effective length and change detect
   always_comb begin
      len_sat  = (cfg_len > DEPTH_L) ? DEPTH_L : cfg_len;
      len_chg  = (len_sat != len_q);
      len_zero = (len_sat == '0);
   end

   // Refill count: restarts on a length change
   always_comb begin
      cnt_eff = len_chg ? '0 : cnt_q;
      filled  = (cnt_eff >= len_sat);
      cnt_nxt = (cnt_eff >= DEPTH_L) ? DEPTH_L : cnt_eff + LEN_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt_q <= '0;
         wp_q  <= '0;
      end else begin
         len_q <= len_sat;
         if (in_valid) begin
            cnt_q <= cnt_nxt;
            wp_q  <= wp_nxt;
         end else if (len_chg) begin
            cnt_q <= '0;
         end
      end
   end

   // Pointer arithmetic: natural wrap for power-of-two depths
   generate
      if (POW2) begin : g_pow2
         always_comb begin
            wp_nxt  = wp_q + AW'(1);
            rd_addr = wp_q - AW'(len_sat);
         end
      end else begin : g_mod
         logic [SUM_W-1:0] diff;
         always_comb begin
            wp_nxt = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            diff   = SUM_W'(wp_q) + SUM_W'(DEPTH) - SUM_W'(len_sat);
            if (diff >= SUM_W'(DEPTH)) begin
               diff = diff - SUM_W'(DEPTH);
            end
            rd_addr = AW'(diff);
         end
      end
   endgenerate

   assign wr_addr = wp_q;

endmodule

// File: rtl/dl_out.sv
module dl_out
   import dl_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              bypass,
   input  logic              len_zero,
   input  logic              filled,
   input  logic [DATA_W-1:0] ram_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   dl_sel_e           sel_nxt;
   dl_sel_e           sel_q;
   logic              vld_q;
   logic [DATA_W-1:0] din_q;

   // Direct path wins over refill guard
   always_comb begin
      if (bypass || len_zero) begin
         sel_nxt = SEL_DIRECT;
      end else if (filled) begin
         sel_nxt = SEL_RAM;
      end else begin
         sel_nxt = SEL_ZERO;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         sel_q <= SEL_ZERO;
         din_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            sel_q <= sel_nxt;
            din_q <= in_data;
         end
      end
   end

   always_comb begin
      out_valid = vld_q;
      out_data  = '0;
      if (vld_q) begin
         unique case (sel_q)
            SEL_RAM:    out_data = ram_data;
            SEL_DIRECT: out_data = din_q;
            default:    out_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line #(
   parameter int  DATA_W = 16,
   parameter int  DEPTH  = 1024,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LEN_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              bypass,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   // Elaboration checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sample_delay_line: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sample_delay_line: DATA_W must be positive");
      end
   endgenerate

   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic              filled;
   logic              len_zero;
   logic [DATA_W-1:0] ram_data;

   dl_ctrl #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .LEN_W (LEN_W)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .cfg_len  (cfg_len),
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .filled   (filled),
      .len_zero (len_zero)
   );

   dl_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .AW     (AW)
   ) ram_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_addr (wr_addr),
      .wr_data (in_data),
      .rd_en   (in_valid),
      .rd_addr (rd_addr),
      .rd_data (ram_data)
   );

   dl_out #(
      .DATA_W (DATA_W)
   ) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .bypass    (bypass),
      .len_zero  (len_zero),
      .filled    (filled),
      .ram_data  (ram_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: rtl/sample_delay_line_chk.sv
module sample_delay_line_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   parameter int LEN_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic [LEN_W-1:0]  cfg_len,
   input logic              bypass,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);

   function automatic logic [LEN_W-1:0] eff(input logic [LEN_W-1:0] l);
      return (l > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : l;
   endfunction

   a_r1_idle_in_reset: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_data == '0);

   a_r5_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bypass) |=> out_data == $past(in_data));

   a_r6_len0_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_len == '0) |=> out_data == $past(in_data));

   a_r4_change_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !bypass && cfg_len != '0 && eff(cfg_len) != eff($past(cfg_len)))
      |=> out_data == '0);

endmodule

bind sample_delay_line sample_delay_line_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .LEN_W  (LEN_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .cfg_len   (cfg_len),
   .bypass    (bypass),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sample_delay_line_tb_top.sv
module sample_delay_line_tb_top;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 1024;
   localparam int LEN_W  = $clog2(DEPTH + 1);
   localparam int HMASK  = 4095;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic [LEN_W-1:0]  cfg_len = '0;
   logic              bypass = 1'b0;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Model state
   logic [DATA_W-1:0] hist [HMASK+1];
   int    n_acc = 0;
   int    m_lenq = 0;
   int    m_cnt = 0;
   bit    have_exp = 0;
   bit    exp_v;
   logic [DATA_W-1:0] exp_d;
   string exp_tag;

   always #4 clk = ~clk;

   sample_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
      .cfg_len (cfg_len), .bypass (bypass), .out_valid (out_valid), .out_data (out_data)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Expected output for a sample, from the requirements
   function automatic void model(input bit v, input logic [DATA_W-1:0] d,
                                 input int len, input bit byp);
      int  ls;
      bit  chg;
      int  ce;
      ls  = (len > DEPTH) ? DEPTH : len;
      chg = (ls != m_lenq);
      ce  = chg ? 0 : m_cnt;
      exp_v = v;
      exp_d = '0;
      if (!v) begin
         exp_tag = "R7";
         if (chg) m_cnt = 0;
      end else begin
         if (byp) begin
            exp_tag = "R5"; exp_d = d;
         end else if (ls == 0) begin
            exp_tag = "R6"; exp_d = d;
         end else if (ce < ls) begin
            exp_tag = "R4"; exp_d = '0;
         end else begin
            exp_d = hist[(n_acc - ls) & HMASK];
            if (len > DEPTH)       exp_tag = "R8";
            else if (ls == DEPTH)  exp_tag = "R9";
            else                   exp_tag = "R3";
         end
         hist[n_acc & HMASK] = d;
         n_acc++;
         m_cnt = (ce >= DEPTH) ? DEPTH : ce + 1;
      end
      m_lenq = ls;
   endfunction

   task automatic step(input bit v, input logic [DATA_W-1:0] d, input int len, input bit byp);
      @(negedge clk);
      if (have_exp) begin
         check("R2", "out_valid", int'(out_valid), int'(exp_v));
         check(exp_tag, "out_data", int'(out_data), int'(exp_d));
      end
      in_valid = v;
      in_data  = d;
      cfg_len  = LEN_W'(len);
      bypass   = byp;
      model(v, d, len, byp);
      have_exp = 1;
   endtask

   task automatic run(input int cycles, input int len, input int pct_valid, input int pct_byp);
      for (int i = 0; i < cycles; i++) begin
         step(($urandom % 100) < pct_valid, DATA_W'($urandom),
              len, ($urandom % 100) < pct_byp);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      cfg_len = LEN_W'(4);
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "out_data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "out_data after reset", int'(out_data), 0);

      // R3 and R4: short delay, continuous input
      run(30, 4, 100, 0);
      // R2: gaps do not shift the delay
      run(200, 17, 60, 0);
      // R4 and R5: change length, bypass in the middle of the refill
      run(3, 9, 100, 0);
      run(4, 9, 100, 100);
      run(60, 9, 100, 0);
      // R6: zero length, then length one
      run(20, 0, 100, 0);
      run(20, 1, 100, 0);
      run(10, 0, 80, 0);
      // R9: max length through several wraps
      run(2300, DEPTH, 100, 0);
      // R8: values above depth act as depth, no refill between them
      run(300, 2000, 100, 0);
      run(50, 1500, 90, 0);
      // R3: one below max
      run(1100, DEPTH - 1, 100, 0);
      // Random phase
      for (int seg = 0; seg < 16; seg++) begin
         int pick;
         int len;
         pick = $urandom % 6;
         case (pick)
            0: len = 0;
            1: len = DEPTH;
            2: len = DEPTH + 1 + ($urandom % 900);
            3: len = 1 + ($urandom % 8);
            default: len = $urandom % 200;
         endcase
         run(250, len, 50 + ($urandom % 51), 8);
      end
      // Flush and R7 idle check
      step(1'b0, '0, 5, 1'b0);
      step(1'b0, '0, 5, 1'b0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired before the stimulus finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule